// File: doc/BRIEF.md
# Nibble-Split DRAM Controller

This block runs a 64 Kbyte byte-wide store built from two 4-bit-wide DRAM parts. One part holds bits 7:4 of every byte and the other holds bits 3:0. Both parts share one 8-bit multiplexed address bus and one set of RAS, CAS and write-enable strobes, so every byte access is a single cycle sequence that drives both parts at once. The 16-bit byte address is split: bits 15:8 go out as the row and bits 7:0 as the column.

Three requesters share the store. They are the print-head fetch (index 0), the interface-receive path (index 1) and the processor (index 2). Each presents a request level, a direction, an address and write data. It gets back a grant for the duration of its access, a one-clock done pulse, and read data on a shared return bus. A refresh timer inserts a CAS-before-RAS refresh cycle at a fixed interval, and that refresh takes precedence over all requesters.

The sequencer has eleven states. From ST_IDLE it goes to ST_RF_CAS when a refresh is pending, otherwise to ST_SETUP when any requester is selected, otherwise it stays in ST_IDLE. An access runs ST_SETUP → ST_RAS_A → ST_RAS_B → ST_CAS_A → ST_CAS_B → ST_PRECH → ST_IDLE. A refresh runs ST_RF_CAS → ST_RF_A → ST_RF_B → ST_RF_PRE → ST_IDLE. Every transition other than the one out of ST_IDLE is unconditional.

Top module: `nibble_dram_ctrl`

## Requirements
- R1: While reset is held, mem_ras_n, mem_cas_n and mem_we_n are 1, and rq_grant, rq_done and mem_oe are 0.
- R2: An access lasts 6 cycles. It starts in the cycle its grant rises (cycle g) with the row (address bits 15:8) on mem_addr. RAS falls at g+1. CAS falls at g+3 with the column (address bits 7:0) on mem_addr. Both strobes are high again at g+5.
- R3: A write drives mem_we_n low and mem_oe high from g+1 through g+4. It places write-data bits 7:4 on mem_dq_hi_o and bits 3:0 on mem_dq_lo_o, so both parts are written at the same CAS edge.
- R4: Read data returned on rq_rdata is {mem_dq_hi_i, mem_dq_lo_i}, sampled in the last cycle before CAS rises (g+4). It is valid while done is high.
- R5: rq_grant is one-hot or zero. It stays on the owner's bit from g through g+5, and the owner's rq_done bit pulses for exactly one clock at g+5.
- R6: When several requesters are pending in ST_IDLE, index 0 (print head) is served before index 1 (interface receive), and index 1 before index 2 (processor).
- R7: A refresh is CAS-before-RAS. CAS falls while RAS is high with mem_we_n high. In the next cycle both strobes are low, and they stay low for 2 cycles before a precharge cycle. A refresh becomes due every REF_PERIOD (312) clocks, so consecutive refresh starts lie within REF_PERIOD±8 cycles of each other.
- R8: A due refresh is taken at the next ST_IDLE ahead of any pending request, so refresh keeps its interval even under back-to-back requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (DRAM bus timebase) |
| rst_n | input | 1 | Active-low synchronous reset |
| rq_valid | input | 3 | Request level per requester; held until its done |
| rq_write | input | 3 | Direction per requester, 1 = write |
| rq_addr | input | 48 | Byte address per requester, 16 bits each, index 0 in bits 15:0 |
| rq_wdata | input | 24 | Write byte per requester, 8 bits each |
| rq_grant | output | 3 | Owner of the access in progress |
| rq_done | output | 3 | One-clock completion pulse to the owner |
| rq_rdata | output | 8 | Read byte of the last access |
| mem_addr | output | 8 | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, shared by both parts |
| mem_cas_n | output | 1 | Column strobe, shared by both parts |
| mem_we_n | output | 1 | Write enable, shared by both parts |
| mem_oe | output | 1 | Write-data drive enable |
| mem_dq_hi_o | output | 4 | Write data to the upper-nibble part |
| mem_dq_lo_o | output | 4 | Write data to the lower-nibble part |
| mem_dq_hi_i | input | 4 | Read data from the upper-nibble part |
| mem_dq_lo_i | input | 4 | Read data from the lower-nibble part |

## Verification
The assertions assume that each requester keeps its request level, address, direction and data steady from the time it raises the request until its done pulse, and then drops the request before the following idle cycle. The done-ownership and single-grant properties rely on this. The bench's handshake agent clears a requester's valid bit on the same falling edge where it sees that requester's done. It raises new requests only on falling edges, so the level seen in ST_IDLE is always stable. The refresh-interval property also takes the parameter defaults as given. The bench's memory model returns read data only while both strobes are low, which matches the sampling window the controller uses.

// File: rtl/nd_pkg.sv
package nd_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RAS_A,
        ST_RAS_B,
        ST_CAS_A,
        ST_CAS_B,
        ST_PRECH,
        ST_RF_CAS,
        ST_RF_A,
        ST_RF_B,
        ST_RF_PRE
    } seq_state_t;
endpackage

// File: rtl/nd_refresh_timer.sv
module nd_refresh_timer #(
    parameter int REF_PERIOD = 312
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(REF_PERIOD);
    localparam logic [CW-1:0] RELOAD = CW'(REF_PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= RELOAD;
            pending <= 1'b0;
        end else if (cnt == '0) begin
            cnt     <= RELOAD;
            pending <= 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
            if (ack) pending <= 1'b0;
        end
    end
endmodule

// File: rtl/nd_arbiter.sv
module nd_arbiter #(
    parameter int NREQ = 3
) (
    input  logic [NREQ-1:0] req,
    input  logic            block,
    output logic [NREQ-1:0] sel
);
    // lowest index wins
    always_comb begin
        logic found;
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (req[i] && !found && !block) begin
                sel[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/nd_sequencer.sv
module nd_sequencer
    import nd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pending,
    input  logic any_sel,
    output logic ref_ack,
    output logic capture,
    output logic ras_n,
    output logic cas_n,
    output logic row_phase,
    output logic col_phase,
    output logic data_phase,
    output logic latch_rd,
    output logic done_phase,
    output logic busy
);
    seq_state_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (ref_pending)  nxt = ST_RF_CAS;
                else if (any_sel) nxt = ST_SETUP;
            end
            ST_SETUP:  nxt = ST_RAS_A;
            ST_RAS_A:  nxt = ST_RAS_B;
            ST_RAS_B:  nxt = ST_CAS_A;
            ST_CAS_A:  nxt = ST_CAS_B;
            ST_CAS_B:  nxt = ST_PRECH;
            ST_PRECH:  nxt = ST_IDLE;
            ST_RF_CAS: nxt = ST_RF_A;
            ST_RF_A:   nxt = ST_RF_B;
            ST_RF_B:   nxt = ST_RF_PRE;
            ST_RF_PRE: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        ref_ack    = 1'b0;
        capture    = 1'b0;
        ras_n      = 1'b1;
        cas_n      = 1'b1;
        row_phase  = 1'b0;
        col_phase  = 1'b0;
        data_phase = 1'b0;
        latch_rd   = 1'b0;
        done_phase = 1'b0;
        busy       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ref_ack = ref_pending;
                capture = !ref_pending && any_sel;
            end
            ST_SETUP: begin
                row_phase = 1'b1;
                busy      = 1'b1;
            end
            ST_RAS_A, ST_RAS_B: begin
                ras_n      = 1'b0;
                row_phase  = 1'b1;
                data_phase = 1'b1;
                busy       = 1'b1;
            end
            ST_CAS_A: begin
                ras_n      = 1'b0;
                cas_n      = 1'b0;
                col_phase  = 1'b1;
                data_phase = 1'b1;
                busy       = 1'b1;
            end
            ST_CAS_B: begin
                ras_n      = 1'b0;
                cas_n      = 1'b0;
                col_phase  = 1'b1;
                data_phase = 1'b1;
                latch_rd   = 1'b1;
                busy       = 1'b1;
            end
            ST_PRECH: begin
                col_phase  = 1'b1;
                done_phase = 1'b1;
                busy       = 1'b1;
            end
            ST_RF_CAS: cas_n = 1'b0;
            ST_RF_A, ST_RF_B: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            ST_RF_PRE: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/nibble_dram_ctrl.sv
module nibble_dram_ctrl #(
    parameter int NREQ       = 3,
    parameter int AW         = 16,
    parameter int DW         = 8,
    parameter int REF_PERIOD = 312
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREQ-1:0]    rq_valid,
    input  logic [NREQ-1:0]    rq_write,
    input  logic [NREQ*AW-1:0] rq_addr,
    input  logic [NREQ*DW-1:0] rq_wdata,
    output logic [NREQ-1:0]    rq_grant,
    output logic [NREQ-1:0]    rq_done,
    output logic [DW-1:0]      rq_rdata,
    output logic [AW/2-1:0]    mem_addr,
    output logic               mem_ras_n,
    output logic               mem_cas_n,
    output logic               mem_we_n,
    output logic               mem_oe,
    output logic [DW/2-1:0]    mem_dq_hi_o,
    output logic [DW/2-1:0]    mem_dq_lo_o,
    input  logic [DW/2-1:0]    mem_dq_hi_i,
    input  logic [DW/2-1:0]    mem_dq_lo_i
);
    localparam int RW = AW / 2;
    localparam int NW = DW / 2;

    logic [NREQ-1:0] sel, owner_q;
    logic [AW-1:0]   addr_a [NREQ];
    logic [DW-1:0]   wd_a   [NREQ];
    logic [AW-1:0]   sel_addr, addr_q;
    logic [DW-1:0]   sel_wd, wdata_q, rdata_q;
    logic            sel_we, we_q;
    logic            ref_pending, ref_ack, capture;
    logic            row_phase, col_phase, data_phase, latch_rd, done_phase, busy;

    for (genvar g = 0; g < NREQ; g++) begin : g_unpack
        assign addr_a[g] = rq_addr[g*AW +: AW];
        assign wd_a[g]   = rq_wdata[g*DW +: DW];
    end

    nd_refresh_timer #(.REF_PERIOD(REF_PERIOD)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pending)
    );

    nd_arbiter #(.NREQ(NREQ)) u_arb (
        .req   (rq_valid),
        .block (ref_pending),
        .sel   (sel)
    );

    nd_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_pending (ref_pending),
        .any_sel     (|sel),
        .ref_ack     (ref_ack),
        .capture     (capture),
        .ras_n       (mem_ras_n),
        .cas_n       (mem_cas_n),
        .row_phase   (row_phase),
        .col_phase   (col_phase),
        .data_phase  (data_phase),
        .latch_rd    (latch_rd),
        .done_phase  (done_phase),
        .busy        (busy)
    );

    always_comb begin
        sel_addr = '0;
        sel_wd   = '0;
        sel_we   = 1'b0;
        for (int i = 0; i < NREQ; i++) begin
            if (sel[i]) begin
                sel_addr = addr_a[i];
                sel_wd   = wd_a[i];
                sel_we   = rq_write[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (capture) begin
                owner_q <= sel;
                addr_q  <= sel_addr;
                wdata_q <= sel_wd;
                we_q    <= sel_we;
            end
            if (latch_rd) rdata_q <= {mem_dq_hi_i, mem_dq_lo_i};
        end
    end

    assign rq_grant    = busy ? owner_q : '0;
    assign rq_done     = done_phase ? owner_q : '0;
    assign rq_rdata    = rdata_q;
    assign mem_addr    = row_phase ? addr_q[AW-1:RW] : (col_phase ? addr_q[RW-1:0] : '0);
    assign mem_oe      = data_phase && we_q;
    assign mem_we_n    = !(data_phase && we_q);
    assign mem_dq_hi_o = wdata_q[DW-1:NW];
    assign mem_dq_lo_o = wdata_q[NW-1:0];
endmodule

// File: rtl/nd_checker.sv
module nd_checker #(
    parameter int NREQ       = 3,
    parameter int REF_PERIOD = 312
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NREQ-1:0] rq_grant,
    input logic [NREQ-1:0] rq_done,
    input logic            mem_ras_n,
    input logic            mem_cas_n,
    input logic            mem_we_n,
    input logic            mem_oe
);
    localparam int GAP_LIMIT = REF_PERIOD + 10;

    logic cas_prev;
    int   gap_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cas_prev <= 1'b1;
            gap_cnt  <= 0;
        end else begin
            cas_prev <= mem_cas_n;
            if (!mem_cas_n && mem_ras_n && cas_prev) gap_cnt <= 0;
            else                                     gap_cnt <= gap_cnt + 1;
        end
    end

    assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rq_grant));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|rq_done) |=> !(|rq_done));

    assert_done_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|rq_done) |-> (rq_done == rq_grant));

    assert_ras_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_cas_n) && !mem_ras_n) |-> ($past(!mem_ras_n) && $past(!mem_ras_n, 2)));

    assert_cbr_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cas_n && mem_ras_n) |=> (!mem_ras_n && !mem_cas_n));

    assert_refresh_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cas_n && mem_ras_n) |-> mem_we_n);

    assert_refresh_interval_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt <= GAP_LIMIT);

    assert_write_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe);
endmodule

bind nibble_dram_ctrl nd_checker #(.NREQ(NREQ), .REF_PERIOD(REF_PERIOD)) u_nd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rq_grant  (rq_grant),
    .rq_done   (rq_done),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .mem_oe    (mem_oe)
);

// File: tb/nibble_dram_ctrl_bench.sv
`timescale 1ns/1ps
module nibble_dram_ctrl_bench;
    localparam int NREQ = 3, AW = 16, DW = 8, REF_PERIOD = 312;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [NREQ-1:0]    rq_valid, rq_write;
    logic [NREQ*AW-1:0] rq_addr;
    logic [NREQ*DW-1:0] rq_wdata;
    logic [NREQ-1:0]    rq_grant, rq_done;
    logic [DW-1:0]      rq_rdata;
    logic [AW/2-1:0]    mem_addr;
    logic               mem_ras_n, mem_cas_n, mem_we_n, mem_oe;
    logic [3:0]         mem_dq_hi_o, mem_dq_lo_o, mem_dq_hi_i, mem_dq_lo_i;

    always #2.5 clk = ~clk;

    nibble_dram_ctrl u_nibble_dram_ctrl (.*);

    typedef struct {
        int         idx;
        bit         wr;
        int         addr;
        logic [7:0] data;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] dmem   [int];
    logic [7:0] shadow [int];
    int tests = 0, fails = 0, nref = 0;
    bit finished = 0;

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37) ^ (a >> 8) ^ 8'h5A);
    endfunction

    function automatic logic [7:0] mget(int a);
        if (dmem.exists(a)) return dmem[a];
        return pat(a);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic push(int idx, bit wr, int addr, logic [7:0] data);
        item_t it;
        it.idx = idx; it.wr = wr; it.addr = addr;
        if (wr) begin
            shadow[addr] = data;
            it.data = data;
        end else begin
            it.data = shadow.exists(addr) ? shadow[addr] : pat(addr);
        end
        exp_q.push_back(it);
    endtask

    task automatic start(int idx, bit wr, int addr, logic [7:0] data);
        rq_addr[idx*AW +: AW]  = AW'(addr);
        rq_wdata[idx*DW +: DW] = data;
        rq_write[idx]          = wr;
        rq_valid[idx]          = 1'b1;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic do_op(int idx, bit wr, int addr, logic [7:0] data);
        push(idx, wr, addr, data);
        start(idx, wr, addr, data);
        drain();
    endtask

    // memory model and scoreboard monitor
    logic p_ras, p_cas;
    logic [NREQ-1:0] p_gnt;
    int cyc, row, col, ras_fall, cas_fall, gcyc, last_ref;
    bit cbr_chk;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_ras = 1'b1; p_cas = 1'b1; p_gnt = '0;
            cyc = 0; last_ref = -1; cbr_chk = 0;
            mem_dq_hi_i = 4'h0; mem_dq_lo_i = 4'h0;
        end else begin
            item_t it;
            cyc++;
            if (cbr_chk) begin
                chk(!mem_ras_n && !mem_cas_n, "R7", "both strobes low after CAS-first",
                    {mem_ras_n, mem_cas_n}, 0);
                cbr_chk = 0;
            end
            if (!mem_cas_n && p_cas && mem_ras_n) begin
                chk(mem_we_n == 1'b1, "R7", "we_n during refresh", mem_we_n, 1);
                if (last_ref >= 0)
                    chk((cyc - last_ref) >= REF_PERIOD - 8 && (cyc - last_ref) <= REF_PERIOD + 8,
                        "R7", "refresh spacing", cyc - last_ref, REF_PERIOD);
                last_ref = cyc;
                nref++;
                cbr_chk = 1;
            end
            if (!mem_ras_n && p_ras) begin
                row = int'(mem_addr);
                ras_fall = cyc;
            end
            if (!mem_cas_n && p_cas && !mem_ras_n) begin
                col = int'(mem_addr);
                cas_fall = cyc;
                if (!mem_we_n) begin
                    chk(mem_oe, "R3", "oe with we_n", mem_oe, 1);
                    dmem[row * 256 + col] = {mem_dq_hi_o, mem_dq_lo_o};
                end
            end
            if (!mem_cas_n && !mem_ras_n)
                {mem_dq_hi_i, mem_dq_lo_i} = mget(row * 256 + col);
            if (rq_grant != '0 && p_gnt == '0) gcyc = cyc;
            if (rq_done != '0) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R5", "done without request", int'(rq_done), 0);
                end else begin
                    it = exp_q.pop_front();
                    chk(rq_done == NREQ'(1 << it.idx), "R6", "done owner / order",
                        int'(rq_done), 1 << it.idx);
                    chk(cyc == gcyc + 5, "R5", "done cycle after grant", cyc - gcyc, 5);
                    chk(ras_fall == gcyc + 1 && cas_fall == gcyc + 3, "R2", "RAS/CAS fall offsets",
                        (ras_fall - gcyc) * 16 + (cas_fall - gcyc), 16 * 1 + 3);
                    chk(row * 256 + col == it.addr, "R2", "row/column address",
                        row * 256 + col, it.addr);
                    if (it.wr)
                        chk(mget(it.addr) == it.data, "R3", "nibbles written",
                            int'(mget(it.addr)), int'(it.data));
                    else
                        chk(rq_rdata == it.data, "R4", "read byte", int'(rq_rdata), int'(it.data));
                end
                rq_valid = rq_valid & ~rq_done;
            end
            p_ras = mem_ras_n; p_cas = mem_cas_n; p_gnt = rq_grant;
        end
    end

    initial begin
        rq_valid = '0; rq_write = '0; rq_addr = '0; rq_wdata = '0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(mem_ras_n && mem_cas_n && mem_we_n, "R1", "strobes in reset",
            {mem_ras_n, mem_cas_n, mem_we_n}, 7);
        chk(rq_grant == '0 && rq_done == '0 && !mem_oe, "R1", "grant/done/oe in reset",
            {rq_grant, rq_done, mem_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // writes from each requester, boundary addresses
        do_op(0, 1, 16'h1234, 8'hA5);
        do_op(1, 1, 16'hFFFF, 8'h3C);
        do_op(2, 1, 16'h0000, 8'hF0);
        do_op(0, 1, 16'h12FF, 8'h0F);
        // reads of written and untouched locations
        do_op(2, 0, 16'h1234, 8'h00);
        do_op(0, 0, 16'hFFFF, 8'h00);
        do_op(1, 0, 16'h0000, 8'h00);
        do_op(2, 0, 16'h12FF, 8'h00);
        do_op(1, 0, 16'h8001, 8'h00);

        // R6: all three at once, expected order 0,1,2
        push(0, 1, 16'h4000, 8'h11);
        push(1, 1, 16'h4001, 8'h22);
        push(2, 1, 16'h4002, 8'h33);
        start(2, 1, 16'h4002, 8'h33);
        start(1, 1, 16'h4001, 8'h22);
        start(0, 1, 16'h4000, 8'h11);
        drain();
        // R6: processor and receive together, receive first
        push(1, 0, 16'h4002, 8'h00);
        push(2, 0, 16'h4000, 8'h00);
        start(2, 0, 16'h4000, 8'h00);
        start(1, 0, 16'h4002, 8'h00);
        drain();

        // R8: saturating processor traffic; refresh must still be taken
        begin
            int base_ref;
            base_ref = nref;
            for (int i = 0; i < 200; i++)
                do_op(2, (i % 3) != 0, (i * 523) & 16'hFFFF, 8'(i * 7));
            chk(nref - base_ref >= 4, "R8", "refreshes under load", nref - base_ref, 4);
        end
        do_op(0, 0, (3 * 523) & 16'hFFFF, 8'h00);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule